// File: doc/BRIEF.md
# Interleaving Video Word Serializer with Scrambling and NRZI Coding

This block turns a stream of 20-bit parallel video words into a single serial bit stream. Each word holds two 10-bit samples, a luma sample in the upper half and a chroma sample in the lower half. The two samples are placed into one serial sequence and sent out one bit per bit-clock enable, twenty bits per word. The serial bits then pass through a self-synchronising scrambler with generator x^9 + x^4 + 1, followed by an NRZ-to-NRZI converter with generator x + 1.

An 8-bit input mode widens byte samples to 10 bits. Bytes that form timing-reference codes (all ones or all zeros) map to the full 10-bit code values. One bypass input removes both coding stages together, for streams that are already coded. A separate clear input resets the scrambler and NRZI history without disturbing word framing.

The block runs on one system clock. A one-cycle `bit_en` pulse advances the serial path by one bit. The source presents the next word and watches `word_load` to see when it is taken.

Top module: `vid_serializer`

## Requirements
- R1: `word_in[19:10]` is the luma sample and `word_in[9:0]` the chroma sample. Each loaded word yields exactly 20 serial bits: the chroma sample first, then the luma sample, each least significant bit first.
- R2: `word_load` is high exactly when `bit_en` is high during the 20th bit of the current word. `word_in` is captured in that clock cycle. After reset, 20 zero bits are sent before the first captured word.
- R3: `ser_out` changes only on the clock edge that ends a cycle with `bit_en` high. In cycles without `bit_en`, the output and the word position hold.
- R4: With `mode_8b` low, both 10-bit samples are serialized unchanged.
- R5: With `mode_8b` high, each sample's byte is taken from its bits [9:2] and padded with two low zero bits. The two lowest input bits of each sample are ignored.
- R6: With `mode_8b` high, a byte of 0xFF becomes 0x3FF and a byte of 0x00 becomes 0x000.
- R7: With coding active, the scrambled bit is s(n) = d(n) XOR s(n-4) XOR s(n-9). Its history starts at zero after reset or clear.
- R8: With coding active, `ser_out` = s(n) XOR the previous NRZI output. The previous output starts at zero after reset or clear.
- R9: With `bypass` high, `ser_out` equals the serialized data bit. The scrambler and NRZI history keep their values until coding resumes.
- R10: With `coder_clr` high in a cycle, the scrambler and NRZI history are zero afterwards. A bit sent in that cycle equals the unmodified data bit.
- R11: `rst_n` low at a clock edge (synchronous) sets `ser_out` to 0, the word position to the first bit, the held word to zero and all coding history to zero. This holds even when `bit_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_en | input | 1 | One-cycle pulse that advances one serial bit |
| word_in | input | 20 | Parallel word: luma [19:10], chroma [9:0] |
| mode_8b | input | 1 | 1 = 8-bit samples with sync widening, 0 = 10-bit samples |
| bypass | input | 1 | 1 = skip the scrambler and NRZI stages |
| coder_clr | input | 1 | 1 = clear scrambler and NRZI history |
| ser_out | output | 1 | Serial output bit |
| word_load | output | 1 | High when `word_in` is captured this cycle |

## Verification
`word_load` is combinational. It is sampled one nanosecond after the inputs change, before the clock edge that acts on them. `ser_out` goes through a single register, so the bench compares it in the same clock period, at the falling edge after the edge that handled `bit_en`. A captured word shows up only from the next bit-enable onward. Its first bit is due 20 enabled bits after the load that precedes it, and the bench reference model keeps exactly that one-word offset. Idle cycles are inserted between enables so that the hold behaviour is checked at the same falling-edge sampling point.

// File: rtl/vs_pkg.sv
// Package: shared sizing for the video word serializer.
// Assumes two equal sample lanes per parallel word.
package vs_pkg;
    parameter int HALF_W  = 10;   // bits per sample
    parameter int BYTE_W  = 8;    // significant bits in 8-bit mode
    parameter int LANES   = 2;    // chroma lane 0, luma lane 1
    parameter int SCR_LEN = 9;    // scrambler register length
    parameter int SCR_TAP = 4;    // inner scrambler tap
    localparam int WORD_W = LANES * HALF_W;
endpackage

// File: rtl/vs_sync_map.sv
// Module: vs_sync_map
// Widens one sample lane. In 10-bit mode the sample passes unchanged.
// In 8-bit mode the byte sits in the upper BYTE_W bits. An all-ones byte
// becomes the all-ones code, and every other byte is padded with low zeros
// (so an all-zeros byte becomes zero). Assumes HALF_W > BYTE_W.
module vs_sync_map #(
    parameter int HALF_W = vs_pkg::HALF_W,
    parameter int BYTE_W = vs_pkg::BYTE_W
) (
    input  logic [HALF_W-1:0] half_in,
    input  logic              mode_8b,
    output logic [HALF_W-1:0] half_out
);
    localparam int PAD_W = HALF_W - BYTE_W;

    logic [BYTE_W-1:0] byte_v;
    assign byte_v = half_in[HALF_W-1:PAD_W];

    // Purpose: pick the widened code for this lane.
    always_comb begin
        if (!mode_8b)
            half_out = half_in;
        else if (&byte_v)
            half_out = '1;
        else
            half_out = {byte_v, {PAD_W{1'b0}}};
    end
endmodule

// File: rtl/vs_shifter.sv
// Module: vs_shifter
// Holds the current word and presents one bit per bit_en, index 0 first.
// On the last bit of a word it captures the next mapped word and wraps.
// Assumes word_in is already widened and ordered chroma-low, luma-high.
module vs_shifter #(
    parameter int WORD_W = vs_pkg::WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_en,
    input  logic [WORD_W-1:0] word_in,
    output logic              raw_bit,
    output logic              word_load
);
    localparam int CNT_W = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

    logic [WORD_W-1:0] hold_q;
    logic [CNT_W-1:0]  pos_q;

    assign raw_bit   = hold_q[pos_q];
    assign word_load = bit_en && (pos_q == LAST);

    // Purpose: advance the bit position and capture a new word on wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
            pos_q  <= '0;
        end else if (word_load) begin
            hold_q <= word_in;
            pos_q  <= '0;
        end else if (bit_en) begin
            pos_q  <= pos_q + 1'b1;
        end
    end

    AST_POS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        pos_q <= LAST);                                           // R1
    AST_LOAD_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        word_load |=> (pos_q == '0) && (hold_q == $past(word_in))); // R2
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(pos_q) && $stable(hold_q));           // R3
endmodule

// File: rtl/vs_coder.sv
// Module: vs_coder
// Scrambles the serial bit (s = d ^ s[-TAP] ^ s[-LEN]) and converts it to
// NRZI, registering the result on bit_en. Bypass passes the data bit and
// freezes both histories. Clear zeroes both histories; a bit sent during
// clear leaves unchanged.
module vs_coder #(
    parameter int SCR_LEN = vs_pkg::SCR_LEN,
    parameter int SCR_TAP = vs_pkg::SCR_TAP
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic coder_clr,
    input  logic bypass,
    input  logic raw_bit,
    output logic ser_out
);
    logic [SCR_LEN-1:0] scr_q;   // bit 0 holds the newest scrambled bit
    logic               nrzi_q;  // previous NRZI output
    logic               scr_bit;
    logic               nrzi_bit;

    // Purpose: form the next scrambled and NRZI bits from the history.
    always_comb begin
        scr_bit  = raw_bit ^ scr_q[SCR_TAP-1] ^ scr_q[SCR_LEN-1];
        nrzi_bit = scr_bit ^ nrzi_q;
    end

    // Purpose: update the coder history and the output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scr_q   <= '0;
            nrzi_q  <= 1'b0;
            ser_out <= 1'b0;
        end else if (coder_clr) begin
            scr_q  <= '0;
            nrzi_q <= 1'b0;
            if (bit_en)
                ser_out <= raw_bit;
        end else if (bit_en) begin
            if (bypass) begin
                ser_out <= raw_bit;
            end else begin
                scr_q   <= {scr_q[SCR_LEN-2:0], scr_bit};
                nrzi_q  <= nrzi_bit;
                ser_out <= nrzi_bit;
            end
        end
    end

    AST_OUT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(ser_out));                            // R3
    AST_BYPASS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
        bit_en && bypass |=> ser_out == $past(raw_bit));          // R9
    AST_BYPASS_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        bypass && !coder_clr |=> $stable(scr_q) && $stable(nrzi_q)); // R9
    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        coder_clr |=> (scr_q == '0) && !nrzi_q);                  // R10
    AST_NRZI_LINK: assert property (@(posedge clk) disable iff (!rst_n)
        bit_en && !bypass && !coder_clr |=> ser_out == nrzi_q);   // R8
endmodule

// File: rtl/vid_serializer.sv
// Module: vid_serializer (top)
// Widens each sample lane, orders chroma before luma, serializes LSB first
// on bit_en, then scrambles and NRZI-codes unless bypassed.
// Assumes bit_en is a one-cycle pulse in the clk domain.
module vid_serializer #(
    parameter int HALF_W  = vs_pkg::HALF_W,
    parameter int BYTE_W  = vs_pkg::BYTE_W,
    parameter int LANES   = vs_pkg::LANES,
    parameter int SCR_LEN = vs_pkg::SCR_LEN,
    parameter int SCR_TAP = vs_pkg::SCR_TAP
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    bit_en,
    input  logic [LANES*HALF_W-1:0] word_in,
    input  logic                    mode_8b,
    input  logic                    bypass,
    input  logic                    coder_clr,
    output logic                    ser_out,
    output logic                    word_load
);
    localparam int WORD_W = LANES * HALF_W;

    logic [WORD_W-1:0] mapped_word;
    logic              raw_bit;

    // Lane 0 (chroma) fills the low bits, so it is sent first.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        vs_sync_map #(.HALF_W(HALF_W), .BYTE_W(BYTE_W)) u_map (
            .half_in (word_in[g*HALF_W +: HALF_W]),
            .mode_8b (mode_8b),
            .half_out(mapped_word[g*HALF_W +: HALF_W])
        );
    end

    vs_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_en   (bit_en),
        .word_in  (mapped_word),
        .raw_bit  (raw_bit),
        .word_load(word_load)
    );

    vs_coder #(.SCR_LEN(SCR_LEN), .SCR_TAP(SCR_TAP)) u_code (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_en   (bit_en),
        .coder_clr(coder_clr),
        .bypass   (bypass),
        .raw_bit  (raw_bit),
        .ser_out  (ser_out)
    );
endmodule

// File: tb/sim_vid_serializer.sv
module sim_vid_serializer;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        bit_en;
    logic [19:0] word_in;
    logic        mode_8b;
    logic        bypass;
    logic        coder_clr;
    logic        ser_out;
    logic        word_load;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;

    // Reference state, built from the requirements
    logic [19:0] m_hold;
    int          m_pos;
    logic [8:0]  m_scr;
    logic        m_prev;
    logic        m_out;

    always #2.5 clk = ~clk;

    vid_serializer u0 (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .word_in(word_in),
        .mode_8b(mode_8b), .bypass(bypass), .coder_clr(coder_clr),
        .ser_out(ser_out), .word_load(word_load)
    );

    function automatic logic [9:0] f_map(logic [9:0] h, logic m8);
        if (!m8)                 return h;          // R4
        if (h[9:2] == 8'hFF)     return 10'h3FF;    // R6
        return {h[9:2], 2'b00};                     // R5, R6 (00 -> 000)
    endfunction

    task automatic check(string tag, logic act, logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_hold = '0; m_pos = 0; m_scr = '0; m_prev = 1'b0; m_out = 1'b0;
    endtask

    // Called at a falling edge: drive, check word_load, clock, check ser_out.
    task automatic step(logic en, logic clr);
        logic raw, s;
        string tag;
        bit_en = en; coder_clr = clr;
        #1;
        check("R2 word_load", word_load, en && (m_pos == 19));
        @(posedge clk);
        if (en) begin
            raw = m_hold[m_pos];
            if (clr) begin
                m_out = raw;
            end else if (bypass) begin
                m_out = raw;
            end else begin
                s = raw ^ m_scr[3] ^ m_scr[8];      // R7
                m_scr = {m_scr[7:0], s};
                m_prev = s ^ m_prev;                // R8
                m_out = m_prev;
            end
            if (m_pos == 19) begin
                m_hold = {f_map(word_in[19:10], mode_8b), f_map(word_in[9:0], mode_8b)};
                m_pos = 0;
            end else begin
                m_pos++;
            end
        end
        if (clr) begin m_scr = '0; m_prev = 1'b0; end  // R10
        if (!en)            tag = "R3 idle hold";
        else if (clr)       tag = "R10 clear";
        else if (bypass && mode_8b) tag = "R5 R6 bypass 8-bit";
        else if (bypass)    tag = "R1 R4 R9 bypass";
        else                tag = "R7 R8 coded";
        @(negedge clk);
        check(tag, ser_out, m_out);
    endtask

    task automatic set_word(int cfg, int w);
        logic [9:0] l, c;
        l = 10'((w * 173 + cfg * 59) ^ (w << 3));
        c = 10'((w * 71) ^ 10'h2A5);
        case (w % 6)
            0: l = {8'hFF, l[1:0]};
            1: c = {8'h00, 2'b11};
            2: begin l = 10'h3FF; c = 10'h3FF; end
            3: begin l = 10'h000; c = 10'h000; end
            default: ;
        endcase
        word_in = {l, c};
    endtask

    task automatic run_word(int cfg, int w);
        int sent = 0;
        int k = 0;
        set_word(cfg, w);
        while (sent < 20) begin
            if ((k % 5) == 4) step(1'b0, 1'b0);
            else begin step(1'b1, 1'b0); sent++; end
            k++;
        end
    endtask

    initial begin
        rst_n = 1'b0; bit_en = 1'b0; word_in = '0; mode_8b = 1'b0;
        bypass = 1'b0; coder_clr = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        #1;
        check("R11 reset ser_out", ser_out, 1'b0);
        check("R11 reset word_load", word_load, 1'b0);

        // Sweep: coded 10/8-bit, bypass 10/8-bit, then coded again (R9 freeze)
        for (int cfg = 0; cfg < 5; cfg++) begin
            mode_8b = cfg[0];
            bypass  = (cfg == 2) || (cfg == 3);
            for (int w = 0; w < 18; w++) run_word(cfg, w);
        end

        // Clear while coding: with and without a bit in the same cycle (R10)
        mode_8b = 1'b0; bypass = 1'b0;
        for (int w = 0; w < 4; w++) begin
            set_word(7, w);
            for (int b = 0; b < 20; b++) begin
                if (b == 5)       step(1'b1, 1'b1);
                else if (b == 12) begin step(1'b0, 1'b1); step(1'b1, 1'b0); end
                else              step(1'b1, 1'b0);
            end
        end

        // Synchronous reset with bit_en high mid-word (R11)
        bit_en = 1'b1; rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        check("R11 mid-run reset ser_out", ser_out, 1'b0);
        for (int w = 0; w < 4; w++) run_word(9, w);
        bypass = 1'b1;
        for (int w = 0; w < 3; w++) run_word(10, w);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog R3 actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule